// File: doc/BRIEF.md
# I/O Window Conflict Probe

This block is the per-logical-device probe that configuration software uses to find out whether an I/O port window it intends to assign is already claimed by other hardware. It holds a 16-bit I/O base address, split into two configuration bytes, and a two-bit probe control byte. While probing is switched on and the device is not active, every I/O read inside the window `[base, base + LEN)` is answered with a fixed signature byte. Software can choose either 0x55 or 0xAA. It then reads the window back and compares the result. A corrupted signature shows that another decoder is driving the bus in that range.

I/O reads arrive on a valid/ready request channel and leave on a valid/ready response channel through a single-entry output slot. A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` is high whenever the slot is empty or its response is being taken in the same cycle. A response held with `rsp_ready` low keeps its contents unchanged. Each response carries a drive flag. The bus interface enables its data drivers only when this flag is set. Configuration access uses a plain write strobe and a combinational read-back. The `chk_live` output tells the device's normal decoder that probe mode owns the read path.

Top module: `rc_io_responder`

## Requirements
- R1: A write to configuration index 0x31 stores bit 1 as the probe enable and bit 0 as the signature select. Reading index 0x31 returns {6'b0, enable, select}, so bits [7:2] always read zero.
- R2: Index 0x60 holds base address bits [15:8] and index 0x61 holds bits [7:0]. Both bytes read back the value last written.
- R3: A read address hits when base <= address < base + LEN. The comparison is done without modular wrap, so a window that runs past 0xFFFF covers only up to 0xFFFF.
- R4: A response to a hit taken while the probe is enabled and `dev_active` is low has `rsp_drive` = 1. Its `rsp_data` is 0x55 when select is 1 and 0xAA when select is 0.
- R5: While `dev_active` is high, responses have `rsp_drive` = 0 and `rsp_data` = 0x00, even when the enable bit is set.
- R6: A read that misses the window, or any read while the enable bit is clear, gets a response with `rsp_drive` = 0 and `rsp_data` = 0x00.
- R7: An accepted request produces its response on the next cycle. `req_ready` = !rsp_valid || rsp_ready. A response held while `rsp_ready` is low keeps its data and drive flag, even if the configuration changes.
- R8: `cfg_reset` clears the enable bit, the select bit and both base bytes on the next edge. It takes priority over a configuration write in the same cycle.
- R9: `chk_live` is high exactly when the enable bit is set and `dev_active` is low.
- R10: Reading any configuration index other than 0x31, 0x60 and 0x61 returns 0x00.
- R11: After `rst_n` is low, all configuration state reads zero and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_reset | input | 1 | Configuration-control reset pulse: clears probe and base registers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read-back of the register selected by `cfg_idx` |
| dev_active | input | 1 | Logical device activated (from the activate register) |
| req_valid | input | 1 | I/O read request valid |
| req_ready | output | 1 | I/O read request accepted when high |
| req_addr | input | 16 | I/O read address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_drive | output | 1 | Drive the data bus with `rsp_data` |
| rsp_data | output | 8 | Signature byte, or 0x00 when not driving |
| chk_live | output | 1 | Probe mode currently owns the read path |

## Verification
The hardest case to reach is a response that is held under back-pressure while the configuration changes underneath it. The stimulus accepts a hit with `rsp_ready` low and keeps a second request pending. It rewrites the select bit during the stall and then checks that the stalled signature is unchanged and that the pending request enters only when the consumer frees the slot. The window edges come from a sweep around several bases, one of them near 0xFFFF so that the no-wrap rule is tested. The sweep runs through all eight combinations of enable, select and active.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam logic [7:0] SIG_SEL1 = 8'h55;
  localparam logic [7:0] SIG_SEL0 = 8'hAA;
  localparam logic [7:0] IDX_PROBE = 8'h31;
  localparam logic [7:0] IDX_BASE_TOP = 8'h60;

  typedef struct packed {
    logic       drive;
    logic [7:0] data;
  } rc_rsp_t;
endpackage

// File: rtl/rc_cfg_regs.sv
module rc_cfg_regs
  import rc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [7:0]        idx,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              probe_en,
  output logic              sig_sel,
  output logic [ADDR_W-1:0] base
);
  localparam int NBYTES = ADDR_W / 8;

  logic [1:0] probe_q;
  logic [NBYTES-1:0][7:0] base_q;
  logic [NBYTES-1:0] byte_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) probe_q <= '0;
    else if (we && idx == IDX_PROBE) probe_q <= wdata[1:0];
  end

  // byte k (k=0 is least significant) lives at IDX_BASE_TOP + NBYTES-1-k
  for (genvar k = 0; k < NBYTES; k++) begin : g_base
    localparam logic [7:0] MY_IDX = IDX_BASE_TOP + 8'(NBYTES - 1 - k);
    assign byte_hit[k] = (idx == MY_IDX);
    always_ff @(posedge clk) begin
      if (!rst_n || clr) base_q[k] <= '0;
      else if (we && byte_hit[k]) base_q[k] <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (idx == IDX_PROBE) rdata = {6'b0, probe_q};
    for (int k = 0; k < NBYTES; k++) begin
      if (byte_hit[k]) rdata = base_q[k];
    end
  end

  assign probe_en = probe_q[1];
  assign sig_sel  = probe_q[0];
  assign base     = base_q;
endmodule

// File: rtl/rc_win_cmp.sv
module rc_win_cmp #(
  parameter int ADDR_W = 16,
  parameter int LEN    = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic              hit
);
  localparam int EXT = ADDR_W + 1;
  localparam logic [EXT-1:0] LEN_X = EXT'(LEN);

  logic [EXT-1:0] addr_x, base_x, lim_x;

  assign addr_x = {1'b0, addr};
  assign base_x = {1'b0, base};
  assign lim_x  = base_x + LEN_X;
  assign hit    = (addr_x >= base_x) && (addr_x < lim_x);
endmodule

// File: rtl/rc_rsp_slot.sv
module rc_rsp_slot
  import rc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  rc_rsp_t in_rsp,
  output logic    out_valid,
  input  logic    out_ready,
  output rc_rsp_t out_rsp
);
  logic    v_q;
  rc_rsp_t r_q;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      r_q <= '0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) r_q <= in_rsp;
    end
  end

  assign out_valid = v_q;
  assign out_rsp   = r_q;
endmodule

// File: rtl/rc_io_responder.sv
module rc_io_responder
  import rc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_reset,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_idx,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              dev_active,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_drive,
  output logic [7:0]        rsp_data,
  output logic              chk_live
);
  logic              probe_en, sig_sel, win_hit;
  logic [ADDR_W-1:0] base;
  rc_rsp_t           new_rsp, out_rsp;

  rc_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(cfg_reset), .we(cfg_we),
    .idx(cfg_idx), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .probe_en(probe_en), .sig_sel(sig_sel), .base(base)
  );

  rc_win_cmp #(.ADDR_W(ADDR_W), .LEN(LEN)) u_cmp (
    .addr(req_addr), .base(base), .hit(win_hit)
  );

  assign chk_live = probe_en && !dev_active;

  always_comb begin
    new_rsp.drive = win_hit && chk_live;
    new_rsp.data  = new_rsp.drive ? (sig_sel ? SIG_SEL1 : SIG_SEL0) : 8'h00;
  end

  rc_rsp_slot u_slot (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_rsp(new_rsp),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_rsp(out_rsp)
  );

  assign rsp_drive = out_rsp.drive;
  assign rsp_data  = out_rsp.data;
endmodule

// File: rtl/rc_io_responder_chk.sv
module rc_io_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_reset,
  input logic       dev_active,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic       rsp_drive,
  input logic [7:0] rsp_data,
  input logic       chk_live
);
  // R4
  sig_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_drive |-> (rsp_data == 8'h55 || rsp_data == 8'hAA));

  // R6
  quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_drive |-> rsp_data == 8'h00);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_drive));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R7
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reset |=> !chk_live);

  // R9
  active_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_active |-> !chk_live);
endmodule

bind rc_io_responder rc_io_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_reset(cfg_reset), .dev_active(dev_active),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_drive(rsp_drive), .rsp_data(rsp_data),
  .chk_live(chk_live)
);

// File: tb/sim_rc_io_responder.sv
module sim_rc_io_responder;
  localparam int CLK_P = 10;
  localparam int LEN   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_reset = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_idx = 8'h00, cfg_wdata = 8'h00, cfg_rdata;
  logic dev_active = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [15:0] req_addr = 16'h0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_drive;
  logic [7:0] rsp_data;
  logic chk_live;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  rc_io_responder #(.ADDR_W(16), .LEN(LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_reset(cfg_reset), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dev_active(dev_active), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_drive(rsp_drive), .rsp_data(rsp_data), .chk_live(chk_live)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_expect(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    cfg_idx = idx;
    #1;
    check(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic io_read(input logic [15:0] a, input bit exp_drv, input logic [7:0] exp_d,
                         input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    #1;
    check(req_ready == 1'b1, {tag, " R7 ready"}, req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, {tag, " R7 valid"}, rsp_valid, 1);
    check(rsp_drive == exp_drv, {tag, " drive"}, rsp_drive, exp_drv);
    check(rsp_data == exp_d, {tag, " data"}, rsp_data, exp_d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bases[4];
    bases = '{0, 'h0279, 'h8000, 'hFFFE};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check(rsp_valid == 1'b0, "R11 rsp_valid", rsp_valid, 0);
    cfg_expect(8'h31, 8'h00, "R11 probe");
    cfg_expect(8'h60, 8'h00, "R11 base hi");
    cfg_expect(8'h61, 8'h00, "R11 base lo");

    // R1 upper bits read zero
    cfg_write(8'h31, 8'hFF);
    cfg_expect(8'h31, 8'h03, "R1 masked");
    cfg_write(8'h31, 8'hFE);
    cfg_expect(8'h31, 8'h02, "R1 en only");
    // R2
    cfg_write(8'h60, 8'hA5);
    cfg_write(8'h61, 8'h3C);
    cfg_expect(8'h60, 8'hA5, "R2 hi");
    cfg_expect(8'h61, 8'h3C, "R2 lo");
    // R10
    cfg_expect(8'h30, 8'h00, "R10 idx30");
    cfg_expect(8'h62, 8'h00, "R10 idx62");
    cfg_expect(8'h00, 8'h00, "R10 idx00");

    // R3 R4 R5 R6 R9 sweep
    foreach (bases[bi]) begin
      cfg_write(8'h60, 8'(bases[bi] >> 8));
      cfg_write(8'h61, 8'(bases[bi]));
      for (int m = 0; m < 8; m++) begin
        bit en, sel, act;
        en = m[1]; sel = m[0]; act = m[2];
        cfg_write(8'h31, {6'b0, en, sel});
        dev_active = act;
        #1;
        check(chk_live == (en && !act), "R9 chk_live", chk_live, en && !act);
        for (int off = -3; off < LEN + 3; off++) begin
          int a;
          bit hit, drv;
          a = (bases[bi] + off) & 'hFFFF;
          hit = (a >= bases[bi]) && (a < bases[bi] + LEN);
          drv = hit && en && !act;
          io_read(16'(a), drv, drv ? (sel ? 8'h55 : 8'hAA) : 8'h00,
                  act ? "R5 sweep" : (en ? "R3 R4 sweep" : "R6 sweep"));
        end
      end
    end
    dev_active = 1'b0;

    // R8 clear, and priority over a write in the same cycle
    cfg_write(8'h31, 8'h03);
    cfg_write(8'h60, 8'h12);
    @(negedge clk);
    cfg_reset = 1'b1; cfg_we = 1'b1; cfg_idx = 8'h31; cfg_wdata = 8'h03;
    @(negedge clk);
    cfg_reset = 1'b0; cfg_we = 1'b0;
    cfg_expect(8'h31, 8'h00, "R8 probe cleared");
    cfg_expect(8'h60, 8'h00, "R8 base cleared");
    check(chk_live == 1'b0, "R8 chk_live", chk_live, 0);

    // R7 back-pressure with config change during stall
    cfg_write(8'h60, 8'h01);
    cfg_write(8'h61, 8'h00);
    cfg_write(8'h31, 8'h03);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0101;
    @(negedge clk);
    req_addr = 16'h0000;
    check(rsp_valid && rsp_drive && rsp_data == 8'h55, "R7 first hit", rsp_data, 8'h55);
    check(req_ready == 1'b0, "R7 stalled ready", req_ready, 0);
    cfg_we = 1'b1; cfg_idx = 8'h31; cfg_wdata = 8'h02;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    check(rsp_valid && rsp_drive && rsp_data == 8'h55, "R7 held data", rsp_data, 8'h55);
    check(req_ready == 1'b0, "R7 still stalled", req_ready, 0);
    rsp_ready = 1'b1;
    #1;
    check(req_ready == 1'b1, "R7 ready follows consumer", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && !rsp_drive && rsp_data == 8'h00, "R7 second miss", rsp_data, 0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7 drained", rsp_valid, 0);
    io_read(16'h0103, 1'b1, 8'hAA, "R4 sel0 after stall");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule